// File: doc/BRIEF.md
# SHA-512 Half-Word Sigma/Sum Execution Unit

This unit is an execution slice for a 32-bit processor pipeline. It recognises six register-register instructions that each compute one 32-bit half of a SHA-512 compression or message-schedule function. A 64-bit SHA-512 word is held in two 32-bit registers. The unit joins the two source operands into one 64-bit value and applies a mix of rotations and shifts to it. It then XORs three terms together and returns the low 32 bits.

The decode stage passes the raw instruction word, both operand values and an enable flag for the hash extension. The result is presented one clock later when the output register is enabled. It comes with these indications:
- a recognised flag;
- an illegal-instruction flag, for a recognised instruction issued while the extension is disabled;
- a write enable, which is held low for destination x0;
- the destination register index.

Register file access, writeback and hazard handling belong to the surrounding pipeline.

Top module: `sha512_half_unit`

## Requirements
- R1: The 64-bit value T is built as {src_b, src_a}, with src_a in bits 31:0. With funct7 0101000 the result is the low 32 bits of rotl(T,25) ^ rotl(T,30) ^ rotr(T,28).
- R2: With funct7 0101001 the result is the low 32 bits of rotl(T,23) ^ rotr(T,14) ^ rotr(T,18).
- R3: With funct7 0101010 the result is the low 32 bits of rotr(T,1) ^ rotr(T,7) ^ rotr(T,8).
- R4: With funct7 0101011 the result is the low 32 bits of rotl(T,3) ^ rotr(T,6) ^ rotr(T,19).
- R5: With funct7 0101110 the result is the low 32 bits of rotr(T,1) ^ (zero-extended src_a >> 7) ^ rotr(T,8). Bits of src_b never reach the shifted term.
- R6: With funct7 0101111 the result is the low 32 bits of rotl(T,3) ^ (zero-extended src_a >> 6) ^ rotr(T,19). Bits of src_b never reach the shifted term.
- R7: An instruction is claimed only when all of the following hold:
  - bits 6:0 are 0110011;
  - bits 14:12 are 000;
  - bits 31:25 hold one of the six funct7 codes above.

  Any other word gives out_hit=0, out_illegal=0, out_wen=0, out_rd=0 and out_result=0.
- R8: A claimed instruction issued with hash_en low gives out_hit=1, out_illegal=1, out_wen=0 and out_result=0.
- R9: For a claimed instruction, out_rd carries instruction bits 11:7. When that field is 0 the write is discarded: out_wen=0 while out_hit=1 and out_result still holds the computed value.
- R10: With OUT_REG=1 every output appears exactly one clock after the issue cycle. In that cycle all outputs are 0 while rst is high or when issue_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| hash_en | input | 1 | The SHA-2 hash extension is enabled |
| instr | input | 32 | Raw instruction word |
| src_a | input | 32 | First source operand (low half of T) |
| src_b | input | 32 | Second source operand (high half of T) |
| out_hit | output | 1 | The instruction was claimed by this unit |
| out_illegal | output | 1 | Claimed while the extension was disabled |
| out_wen | output | 1 | Register write requested |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | Computed 32-bit result |

## Verification
The bench builds the unit with OUT_REG=1, the registered variant, so the one-cycle latency and the reset-cleared outputs can be observed at the ports. Under that setting a queue-based scoreboard checks every issue cycle against an independent 64-bit rotation model. The stimulus covers:
- all six functions with walking single-bit patterns across the full 64-bit value;
- all-ones and all-zero operands;
- the same operands with src_a and src_b swapped, which shows the operand order;
- the disabled-extension case, destination x0, and near-miss encodings.

// File: rtl/sha512h_pkg.sv
package sha512h_pkg;
  localparam int DATA_W = 32;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int RD_W   = 5;

  localparam logic [6:0] OPC_ALU_REG = 7'b0110011;
  localparam logic [2:0] F3_CRYPTO   = 3'b000;

  localparam logic [6:0] F7_BIG0   = 7'b0101000;
  localparam logic [6:0] F7_BIG1   = 7'b0101001;
  localparam logic [6:0] F7_SMALL0L = 7'b0101010;
  localparam logic [6:0] F7_SMALL1L = 7'b0101011;
  localparam logic [6:0] F7_SMALL0H = 7'b0101110;
  localparam logic [6:0] F7_SMALL1H = 7'b0101111;

  typedef enum logic [2:0] {
    FN_NONE   = 3'd0,
    FN_BIG0   = 3'd1,
    FN_BIG1   = 3'd2,
    FN_SMALL0L = 3'd3,
    FN_SMALL1L = 3'd4,
    FN_SMALL0H = 3'd5,
    FN_SMALL1H = 3'd6
  } fn_e;

  typedef struct packed {
    logic              hit;
    logic              illegal;
    logic              wen;
    logic [RD_W-1:0]   rd;
    logic [DATA_W-1:0] data;
  } result_t;

  function automatic logic [WIDE_W-1:0] rot_r(input logic [WIDE_W-1:0] x, input int n);
    return (x >> n) | (x << (WIDE_W - n));
  endfunction

  function automatic logic [WIDE_W-1:0] rot_l(input logic [WIDE_W-1:0] x, input int n);
    return (x << n) | (x >> (WIDE_W - n));
  endfunction
endpackage

// File: rtl/sha512h_decode.sv
module sha512h_decode
  import sha512h_pkg::*;
(
  input  logic              issue_valid,
  input  logic [DATA_W-1:0] instr,
  output fn_e               fn,
  output logic [RD_W-1:0]   rd
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign rd  = instr[11:7];

  always_comb begin
    fn = FN_NONE;
    if (issue_valid && opc == OPC_ALU_REG && f3 == F3_CRYPTO) begin
      unique case (f7)
        F7_BIG0:    fn = FN_BIG0;
        F7_BIG1:    fn = FN_BIG1;
        F7_SMALL0L: fn = FN_SMALL0L;
        F7_SMALL1L: fn = FN_SMALL1L;
        F7_SMALL0H: fn = FN_SMALL0H;
        F7_SMALL1H: fn = FN_SMALL1H;
        default:    fn = FN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sha512h_datapath.sv
module sha512h_datapath
  import sha512h_pkg::*;
(
  input  fn_e               fn,
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  output logic [DATA_W-1:0] value
);
  logic [WIDE_W-1:0] joined;
  logic [WIDE_W-1:0] lo_ext;
  logic [WIDE_W-1:0] mix;

  assign joined = {hi_word, lo_word};
  assign lo_ext = {{DATA_W{1'b0}}, lo_word};

  always_comb begin
    unique case (fn)
      FN_BIG0:    mix = rot_l(joined, 25) ^ rot_l(joined, 30) ^ rot_r(joined, 28);
      FN_BIG1:    mix = rot_l(joined, 23) ^ rot_r(joined, 14) ^ rot_r(joined, 18);
      FN_SMALL0L: mix = rot_r(joined, 1)  ^ rot_r(joined, 7)  ^ rot_r(joined, 8);
      FN_SMALL1L: mix = rot_l(joined, 3)  ^ rot_r(joined, 6)  ^ rot_r(joined, 19);
      FN_SMALL0H: mix = rot_r(joined, 1)  ^ (lo_ext >> 7)     ^ rot_r(joined, 8);
      FN_SMALL1H: mix = rot_l(joined, 3)  ^ (lo_ext >> 6)     ^ rot_r(joined, 19);
      default:    mix = '0;
    endcase
  end

  assign value = mix[DATA_W-1:0];
endmodule

// File: rtl/sha512h_outstage.sv
module sha512h_outstage
  import sha512h_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  result_t d,
  output result_t q
);
  generate
    if (OUT_REG) begin : g_reg
      result_t q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_comb
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sha512_half_unit.sv
module sha512_half_unit
  import sha512h_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              hash_en,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_hit,
  output logic              out_illegal,
  output logic              out_wen,
  output logic [RD_W-1:0]   out_rd,
  output logic [DATA_W-1:0] out_result
);
  fn_e               fn;
  logic [RD_W-1:0]   rd_field;
  logic [DATA_W-1:0] value;
  logic              claimed;
  result_t           stage_d;
  result_t           stage_q;

  sha512h_decode i_dec (
    .issue_valid (issue_valid),
    .instr       (instr),
    .fn          (fn),
    .rd          (rd_field)
  );

  sha512h_datapath i_dp (
    .fn      (fn),
    .lo_word (src_a),
    .hi_word (src_b),
    .value   (value)
  );

  assign claimed = (fn != FN_NONE);

  always_comb begin
    stage_d         = '0;
    stage_d.hit     = claimed;
    stage_d.illegal = claimed && !hash_en;
    stage_d.wen     = claimed && hash_en && (rd_field != '0);
    stage_d.rd      = claimed ? rd_field : '0;
    stage_d.data    = (claimed && hash_en) ? value : '0;
  end

  sha512h_outstage #(.OUT_REG(OUT_REG)) i_out (
    .clk (clk),
    .rst (rst),
    .d   (stage_d),
    .q   (stage_q)
  );

  assign out_hit     = stage_q.hit;
  assign out_illegal = stage_q.illegal;
  assign out_wen     = stage_q.wen;
  assign out_rd      = stage_q.rd;
  assign out_result  = stage_q.data;
endmodule

// File: rtl/sha512_half_chk.sv
module sha512_half_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        issue_valid,
  input logic        hash_en,
  input logic [31:0] instr,
  input logic        out_hit,
  input logic        out_illegal,
  input logic        out_wen,
  input logic [4:0]  out_rd,
  input logic [31:0] out_result
);
  assert_x0_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_rd != 5'd0));

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_hit && !out_wen && out_result == 32'd0));

  generate
    if (OUT_REG) begin : g_timed
      assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!out_hit && !out_illegal && !out_wen));

      assert_disabled_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !hash_en) |=> !out_wen);

      assert_foreign_opcode_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && instr[6:0] != 7'b0110011) |=> (!out_hit && out_result == 32'd0));

      assert_rd_follows_R9: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_rd == $past(instr[11:7])));
    end
  endgenerate
endmodule

bind sha512_half_unit sha512_half_chk #(.OUT_REG(OUT_REG)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .hash_en     (hash_en),
  .instr       (instr),
  .out_hit     (out_hit),
  .out_illegal (out_illegal),
  .out_wen     (out_wen),
  .out_rd      (out_rd),
  .out_result  (out_result)
);

// File: tb/test_sha512_half_unit.sv
module test_sha512_half_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        hash_en = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_hit, out_illegal, out_wen;
  logic [4:0]  out_rd;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit        hit;
    bit        ill;
    bit        wen;
    bit [4:0]  rd;
    bit [31:0] data;
    string     tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  sha512_half_unit #(.OUT_REG(1'b1)) i_sha512_half_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .hash_en(hash_en),
    .instr(instr), .src_a(src_a), .src_b(src_b),
    .out_hit(out_hit), .out_illegal(out_illegal), .out_wen(out_wen),
    .out_rd(out_rd), .out_result(out_result)
  );

  function automatic bit [63:0] mrr(bit [63:0] x, int n);
    bit [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic bit [63:0] mrl(bit [63:0] x, int n);
    return mrr(x, 64 - n);
  endfunction

  // idx 0..5: the six functions of R1..R6
  function automatic bit [31:0] model(int idx, bit [31:0] a, bit [31:0] b);
    bit [63:0] t, z, r;
    t = {b, a};
    z = {32'd0, a};
    case (idx)
      0: r = mrl(t,25) ^ mrl(t,30) ^ mrr(t,28);
      1: r = mrl(t,23) ^ mrr(t,14) ^ mrr(t,18);
      2: r = mrr(t,1)  ^ mrr(t,7)  ^ mrr(t,8);
      3: r = mrl(t,3)  ^ mrr(t,6)  ^ mrr(t,19);
      4: r = mrr(t,1)  ^ (z >> 7)  ^ mrr(t,8);
      default: r = mrl(t,3) ^ (z >> 6) ^ mrr(t,19);
    endcase
    return r[31:0];
  endfunction

  function automatic bit [6:0] f7_of(int idx);
    case (idx)
      0: return 7'b0101000;
      1: return 7'b0101001;
      2: return 7'b0101010;
      3: return 7'b0101011;
      4: return 7'b0101110;
      default: return 7'b0101111;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic bit [31:0] mk(bit [6:0] f7, bit [2:0] f3, bit [4:0] rd, bit [6:0] opc);
    return {f7, 5'd3, 5'd4, f3, rd, opc};
  endfunction

  task automatic drive(bit v, bit en, bit [31:0] ins, bit [31:0] a, bit [31:0] b, exp_t e);
    @(negedge clk);
    issue_valid = v;
    hash_en = en;
    instr = ins;
    src_a = a;
    src_b = b;
    sb.push_back(e);
  endtask

  task automatic op(int idx, bit [4:0] rd, bit [31:0] a, bit [31:0] b, string tag);
    exp_t e;
    e.hit = 1; e.ill = 0; e.wen = (rd != 0); e.rd = rd;
    e.data = model(idx, a, b); e.tag = tag;
    drive(1, 1, mk(f7_of(idx), 3'b000, rd, 7'b0110011), a, b, e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    e.hit = 0; e.ill = 0; e.wen = 0; e.rd = 0; e.data = 0; e.tag = tag;
    drive(0, 1, 32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, e);
  endtask

  task automatic foreign(bit [31:0] ins, string tag);
    exp_t e;
    e.hit = 0; e.ill = 0; e.wen = 0; e.rd = 0; e.data = 0; e.tag = tag;
    drive(1, 1, ins, 32'hDEAD_BEEF, 32'h0BAD_F00D, e);
  endtask

  // monitor: one item per clock, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out_hit !== e.hit || out_illegal !== e.ill || out_wen !== e.wen ||
          out_rd !== e.rd || out_result !== e.data) begin
        failures++;
        $display("FAIL %s: got hit=%0b ill=%0b wen=%0b rd=%0d res=%h, expected hit=%0b ill=%0b wen=%0b rd=%0d res=%h",
                 e.tag, out_hit, out_illegal, out_wen, out_rd, out_result,
                 e.hit, e.ill, e.wen, e.rd, e.data);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state, with an instruction presented during reset
    issue_valid = 1;
    instr = mk(7'b0101000, 3'b000, 5'd5, 7'b0110011);
    src_a = 32'hFFFF_FFFF;
    src_b = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_hit !== 0 || out_illegal !== 0 || out_wen !== 0 || out_rd !== 0 || out_result !== 0) begin
      failures++;
      $display("FAIL R10: got hit=%0b res=%h in reset, expected all zero", out_hit, out_result);
    end
    @(negedge clk);
    issue_valid = 0;
    rst = 0;

    idle("R10 idle");
    for (int k = 0; k < 6; k++) begin
      op(k, 5'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, {tag_of(k), " all-ones"});
      op(k, 5'd8, 32'h0000_0000, 32'h0000_0000, {tag_of(k), " zeros"});
      for (int p = 0; p < 64; p++) begin
        bit [63:0] w;
        w = 64'd1 << p;
        op(k, 5'(1 + (p % 31)), w[31:0], w[63:32], {tag_of(k), " walk"});
      end
      // R1 operand order: swapped pair must be computed with its own ordering
      op(k, 5'd9, 32'h0123_4567, 32'h89AB_CDEF, {tag_of(k), " R1 order"});
      op(k, 5'd9, 32'h89AB_CDEF, 32'h0123_4567, {tag_of(k), " R1 swapped"});
      // R5/R6: high src_b bits must not leak via the shift term
      op(k, 5'd10, 32'h0000_0000, 32'hFFFF_FFFF, {tag_of(k), " hi-only"});
      op(k, 5'd11, 32'hFFFF_FFFF, 32'h0000_0000, {tag_of(k), " lo-only"});
      idle("R10 gap");
    end

    begin : lfsr_block
      bit [31:0] s;
      s = 32'hACE1_2468;
      for (int n = 0; n < 60; n++) begin
        bit [31:0] a, b;
        s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        a = s;
        s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        b = s ^ 32'h5A5A_A5A5;
        op(n % 6, 5'(1 + n % 31), a, b, {tag_of(n % 6), " mixed"});
      end
    end

    // R9: destination x0
    for (int k = 0; k < 6; k++)
      op(k, 5'd0, 32'hCAFE_0001, 32'h8000_7777, "R9 x0");

    // R8: extension disabled
    for (int k = 0; k < 6; k++) begin
      exp_t e;
      e.hit = 1; e.ill = 1; e.wen = 0; e.rd = 5'd12; e.data = 0; e.tag = "R8 disabled";
      drive(1, 0, mk(f7_of(k), 3'b000, 5'd12, 7'b0110011), 32'h1111_2222, 32'h3333_4444, e);
    end

    // R7: near-miss encodings
    foreign(mk(7'b0101100, 3'b000, 5'd6, 7'b0110011), "R7 funct7 0101100");
    foreign(mk(7'b0101101, 3'b000, 5'd6, 7'b0110011), "R7 funct7 0101101");
    foreign(mk(7'b0001000, 3'b000, 5'd6, 7'b0110011), "R7 funct7 0001000");
    foreign(mk(7'b0101000, 3'b001, 5'd6, 7'b0110011), "R7 funct3 001");
    foreign(mk(7'b0101011, 3'b100, 5'd6, 7'b0110011), "R7 funct3 100");
    foreign(mk(7'b0101000, 3'b000, 5'd6, 7'b0010011), "R7 opcode 0010011");
    begin
      exp_t e;
      e.hit = 0; e.ill = 0; e.wen = 0; e.rd = 0; e.data = 0; e.tag = "R7 foreign disabled";
      drive(1, 0, mk(7'b0101110, 3'b010, 5'd6, 7'b0110011), 32'h1, 32'h2, e);
    end

    // R10: a valid op right after an idle cycle, then idle again
    idle("R10 idle");
    op(2, 5'd31, 32'h8000_0001, 32'h4000_0002, "R3 boundary rd31");
    idle("R10 idle");
    idle("R10 idle");

    wait (sb.size() == 0);
    @(posedge clk);
    #3;
    finish_run();
  end
endmodule